// File: doc/BRIEF.md
# Asymmetric-Threshold Switch Debouncer

This block turns the bouncing, asynchronous level of a mechanical switch into a clean logic level. The raw input first passes through a two-stage synchronizer. A run counter then counts consecutive clock cycles in which the synchronized sample disagrees with the current debounced level. The debounced output flips only when that run reaches its threshold. Any sample that agrees with the output, even a single one, clears the run. This discards noise spikes and short bounce bursts.

The two directions have separate compile-time thresholds. A switch that needs a long settle time on make can have a short one on break, or the reverse. Each threshold can be any count from 1 up to just under 2^31, and the counter width follows the larger one. For example, a 1 ns clock with a 1 ms settle requirement uses a threshold of 1,000,000. Alongside the level, the block emits a one-cycle pulse for each accepted rising or falling change.

Top module: `switch_debounce`

## Requirements
- R1: While rst_ni is low, level_o, rise_o and fall_o are 0, and the run count is held at zero.
- R2: raw_i passes through two flip-flops before counting. A change on raw_i captured at clock edge m, held long enough, flips level_o at edge m+1+T, where T is the threshold for that direction.
- R3: level_o goes from 0 to 1 only after exactly RISE_CYCLES consecutive synchronized samples of 1.
- R4: level_o goes from 1 to 0 only after exactly FALL_CYCLES consecutive synchronized samples of 0. This threshold is independent of RISE_CYCLES.
- R5: A synchronized sample equal to level_o clears the run count. An opposite run shorter than its threshold has no effect on level_o, however often it repeats.
- R6: rise_o is high for exactly the one cycle in which level_o first reads 1 after a change. fall_o is high for exactly the one cycle in which level_o first reads 0 after a change.
- R7: rise_o and fall_o are never high together, and neither pulses while level_o is steady.
- R8: The run count stays below the larger threshold. Its width is derived from the larger threshold, so any threshold below 2^31 - 1 fits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Raw switch level, asynchronous |
| level_o | output | 1 | Debounced level |
| rise_o | output | 1 | One-cycle pulse on an accepted 0-to-1 change |
| fall_o | output | 1 | One-cycle pulse on an accepted 1-to-0 change |

## Verification
The bench builds the block with RISE_CYCLES=7 and FALL_CYCLES=4. The two thresholds are deliberately unequal, so a design that uses the wrong threshold for a direction misses a predicted event cycle. Both values are small, so runs of exactly the threshold, one short of it, and broken by a single opposite sample all fit within a few hundred cycles. Each accepted change is predicted to the exact cycle from the drive sequence, which also covers the two-stage synchronizer latency.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  function automatic int max_thr(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..max threshold
  function automatic int run_width(input int a, input int b);
    int m;
    m = max_thr(a, b);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10
  } dbn_event_e;

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_q[g-1];
    end

    a_r2_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_q[g] == $past(stage_q[g-1]));
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbn_run_cnt.sv
module dbn_run_cnt #(
  parameter int RISE_CYCLES = 10,
  parameter int FALL_CYCLES = 10,
  parameter int W           = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         level_i,
  output logic         hit_o,
  output logic [W-1:0] cnt_o
);

  localparam int          MAX_THR  = dbn_pkg::max_thr(RISE_CYCLES, FALL_CYCLES);
  localparam logic [W-1:0] RISE_LAST = W'(RISE_CYCLES - 1);
  localparam logic [W-1:0] FALL_LAST = W'(FALL_CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         opp;
  logic [W-1:0] last;

  assign opp   = sample_i != level_i;
  assign last  = level_i ? FALL_LAST : RISE_LAST;
  assign hit_o = opp && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!opp)   cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r5_match_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i == level_i) |=> (cnt_q == '0));

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(MAX_THR));

endmodule

// File: rtl/dbn_level.sv
module dbn_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  import dbn_pkg::*;

  logic       level_q;
  dbn_event_e ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      ev_q    <= EV_NONE;
    end else if (hit_i) begin
      level_q <= ~level_q;
      ev_q    <= level_q ? EV_FALL : EV_RISE;
    end else begin
      ev_q    <= EV_NONE;
    end
  end

  assign level_o = level_q;
  assign rise_o  = ev_q == EV_RISE;
  assign fall_o  = ev_q == EV_FALL;

  a_r6_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (level_q && !$past(level_q)));

  a_r6_fall_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!level_q && $past(level_q)));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  a_r7_steady_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(level_q) |-> !(rise_o || fall_o));

endmodule

// File: rtl/switch_debounce.sv
module switch_debounce #(
  parameter int RISE_CYCLES = 10,
  parameter int FALL_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int SYNC_STAGES = 2;
  localparam int W = dbn_pkg::run_width(RISE_CYCLES, FALL_CYCLES);

  logic         sync_q;
  logic         hit;
  logic [W-1:0] run_cnt;

  dbn_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_q)
  );

  dbn_run_cnt #(
    .RISE_CYCLES(RISE_CYCLES),
    .FALL_CYCLES(FALL_CYCLES),
    .W          (W)
  ) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sync_q),
    .level_i (level_o),
    .hit_o   (hit),
    .cnt_o   (run_cnt)
  );

  dbn_level level_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .level_o(level_o),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  a_r3_rise_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> ($past(run_cnt) == W'(RISE_CYCLES - 1) && $past(sync_q)));

  a_r4_fall_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o) |-> ($past(run_cnt) == W'(FALL_CYCLES - 1) && !$past(sync_q)));

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!level_o && !rise_o && !fall_o && run_cnt == '0));

endmodule

// File: tb/switch_debounce_tb_top.sv
module switch_debounce_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RISE_T = 7;
  localparam int FALL_T = 4;
  localparam int WATCHDOG = 200000;

  typedef struct {
    int   cyc;
    logic rise;
  } exp_ev_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic raw_i = 1'b0;
  logic level_o, rise_o, fall_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  exp_ev_t exp_q[$];
  logic exp_lvl = 1'b0;
  logic last_v = 1'b0;
  int run_len = 0;
  logic mon_lvl = 1'b0;

  switch_debounce #(.RISE_CYCLES(RISE_T), .FALL_CYCLES(FALL_T)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i),
    .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // driver: one raw sample per cycle; predicts the event cycle (R2, R3, R4, R5)
  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_ev_t e;
      @(negedge clk_i);
      raw_i = v;
      if (v == last_v) run_len++;
      else run_len = 1;
      last_v = v;
      if (v != exp_lvl && run_len == (exp_lvl ? FALL_T : RISE_T)) begin
        e.cyc = cyc + 3;
        e.rise = v;
        exp_q.push_back(e);
        exp_lvl = v;
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        check(1'b0, "R2 missed event", 0, exp_q[0].cyc);
        mon_lvl = exp_q[0].rise;
        void'(exp_q.pop_front());
      end
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        if (exp_q[0].rise) begin
          check(rise_o && !fall_o, "R3/R6 rise pulse", {rise_o, fall_o}, 2);
        end else begin
          check(fall_o && !rise_o, "R4/R6 fall pulse", {rise_o, fall_o}, 1);
        end
        mon_lvl = exp_q[0].rise;
        void'(exp_q.pop_front());
      end else begin
        check(!rise_o && !fall_o, "R5/R7 unexpected pulse", {rise_o, fall_o}, 0);
      end
      check(level_o == mon_lvl, "R3/R4 level", level_o, mon_lvl);
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog cyc=%0d actual=0 expected=1", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    raw_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check(level_o == 1'b0 && !rise_o && !fall_o, "R1 reset outputs", {level_o, rise_o, fall_o}, 0);
    raw_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    drive(0, 5);

    // R3: exact rise run; R4: exact fall run
    drive(1, RISE_T);
    drive(1, 3);
    drive(0, FALL_T);
    drive(0, 6);

    // R5: runs one short, broken by single samples
    drive(1, RISE_T - 1); drive(0, 1);
    drive(1, RISE_T - 1); drive(0, 1);
    drive(1, RISE_T - 1); drive(0, 8);
    drive(1, RISE_T + 2);
    drive(0, FALL_T - 1); drive(1, 1);
    drive(0, FALL_T - 1); drive(1, 5);
    drive(0, FALL_T);
    drive(0, 4);

    // bounce bursts then settle, both directions
    for (int k = 0; k < 6; k++) begin
      drive(1, 1 + (k % 3));
      drive(0, 1 + ((k + 1) % 2));
    end
    drive(1, RISE_T + 4);
    for (int k = 0; k < 5; k++) begin
      drive(0, 1 + (k % 3));
      drive(1, 1);
    end
    drive(0, FALL_T + 3);

    // R4: fall threshold independent of rise (run of FALL_T+1 high does not rise)
    drive(1, FALL_T + 1);
    drive(0, 6);

    // back-to-back accepted changes
    drive(1, RISE_T);
    drive(0, FALL_T);
    drive(1, RISE_T);
    drive(1, 6);

    // R1: reset while high forces level low
    drive(1, 4);
    mon_en = 1'b0;
    @(negedge clk_i);
    check(exp_q.size() == 0, "R2 pending events", exp_q.size(), 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(level_o == 1'b0 && !rise_o && !fall_o, "R1 reset mid-run", {level_o, rise_o, fall_o}, 0);
    raw_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_lvl = 1'b0; mon_lvl = 1'b0; last_v = 1'b0; run_len = 0;
    mon_en = 1'b1;
    drive(0, 3);
    drive(1, RISE_T);
    drive(1, 10);
    check(exp_q.size() == 0, "R3 pending events", exp_q.size(), 0);
    check(level_o == 1'b1, "R3 final level", level_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule